// File: doc/BRIEF.md
# Code Segment Selector Loader

This block performs the descriptor lookup that a protected-mode processor carries out when a new code segment selector is loaded. A 16-bit selector arrives with a one-cycle load strobe. The block splits the selector into an entry index, a table-select bit and a requested privilege level. It then finds the entry's byte address in either the global or the local descriptor table, and checks that the whole 8-byte entry lies inside the table limit.

If the entry is in range, the block reads it over a 32-bit request/acknowledge read port as two words. The low word is read first. The block then checks that the entry describes a code segment and that the selector's requested level does not exceed the descriptor's privilege level. The result is one of two things. Either a one-cycle valid pulse, with the unpacked base, 20-bit limit and privilege level. Or a one-cycle fault pulse, with a cause code. A write port sets the base, limit and presence of each table.

Top module: `seg_sel_loader`

## Requirements
- R1: After reset, both tables have base 0 and limit 0xFFFF, and the local table is present. `busy`, `mem_req`, `desc_valid` and `fault` are 0, and `fault_cause` is 0.
- R2: Selector bit 2 chooses the local table (1) or the global table (0). Bits 15:3 are the entry index and bits 1:0 are the requested level. The entry address is table base + index×8. The low word is read at that address and then the high word at address+4. Each request is held with a stable address until `mem_ack`.
- R3: A global-table selector with index 0 raises a fault with cause 1 on the cycle after the strobe, and no read is issued. A local-table index 0 is not treated as null.
- R4: An entry whose offset index×8 + 7 exceeds the table limit raises cause 2 without a read. A local selector while the local table is marked absent also raises cause 2 without a read. The limit counts bytes minus one.
- R5: An entry is accepted as code only if descriptor bits 43 and 44 are both 1. These are bits 11 and 12 of the high word. Otherwise the block raises cause 3.
- R6: The descriptor privilege level is descriptor bits 46:45, which are high-word bits 14:13. A requested level numerically greater than that level raises cause 4. The type check takes precedence over this check.
- R7: An accepted entry gives a one-cycle `desc_valid` on the cycle after the high-word acknowledge. The outputs carry base = {desc[63:56], desc[39:32], desc[31:16]}, limit = {desc[51:48], desc[15:0]}, and the privilege level.
- R8: `busy` is high from the cycle after an accepted strobe until the result. A strobe while busy is ignored. Each load yields exactly one pulse of either `desc_valid` or `fault`, never both. `fault_cause` is 0 whenever `fault` is low.
- R9: A table write (`tbl_wr`) with `tbl_wr_local` 0 sets the global base and limit. With `tbl_wr_local` 1 it sets the local base, limit and presence. The new values take effect for the next strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tbl_wr | input | 1 | Table register write strobe |
| tbl_wr_local | input | 1 | Write target: 1 local table, 0 global table |
| tbl_wr_base | input | 32 | Table base to write |
| tbl_wr_limit | input | 16 | Table limit (size in bytes minus one) to write |
| tbl_wr_present | input | 1 | Local table presence to write |
| sel_load | input | 1 | Selector load strobe |
| sel_in | input | 16 | Selector value |
| busy | output | 1 | A load is in progress |
| mem_req | output | 1 | Descriptor word read request |
| mem_addr | output | 32 | Descriptor word byte address |
| mem_ack | input | 1 | Read acknowledge, data valid |
| mem_rdata | input | 32 | Read data |
| desc_valid | output | 1 | One-cycle pulse: descriptor accepted |
| desc_base | output | 32 | Accepted segment base |
| desc_limit | output | 20 | Accepted segment limit |
| desc_dpl | output | 2 | Accepted descriptor privilege level |
| fault | output | 1 | One-cycle pulse: load rejected |
| fault_cause | output | 3 | 0 none, 1 null, 2 limit, 3 type, 4 privilege |

## Verification
The bench keeps the default 32-bit address width and uses small table limits: 8 global entries and 5 local entries. With these limits, a sweep over indices 0 to 11, all four requested levels and both tables lands on both sides of each limit. The memory model fills entries from an address hash, so the type bits and privilege levels vary from entry to entry. The type and privilege faults and the accept path are therefore all reached. Separate cases cover the reset-state tables, the largest index under a 0xFFFF limit, a limit one byte short of an entry, an absent local table, and a strobe issued while busy.

// File: rtl/seg_pkg.sv
package seg_pkg;
    localparam int SEG_AW      = 32;
    localparam int SEL_W       = 16;
    localparam int TLIM_W      = 16;
    localparam int SLIM_W      = 20;
    localparam int ENT_SHIFT   = 3;
    localparam int IDX_W       = SEL_W - ENT_SHIFT;

    typedef enum logic [2:0] {
        CAUSE_NONE  = 3'd0,
        CAUSE_NULL  = 3'd1,
        CAUSE_LIMIT = 3'd2,
        CAUSE_TYPE  = 3'd3,
        CAUSE_PRIV  = 3'd4
    } cause_e;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_LO   = 2'd1,
        ST_HI   = 2'd2
    } ld_state_e;

    typedef struct packed {
        logic [SEG_AW-1:0] base;
        logic [TLIM_W-1:0] limit;
        logic              present;
    } tbl_reg_t;
endpackage

// File: rtl/seg_sel_decode.sv
module seg_sel_decode
    import seg_pkg::*;
(
    input  logic [SEL_W-1:0]  sel,
    input  tbl_reg_t          gtab,
    input  tbl_reg_t          ltab,
    output logic [1:0]        rpl,
    output logic              is_null,
    output logic              in_range,
    output logic [SEG_AW-1:0] entry_addr
);
    logic              use_local;
    logic [IDX_W-1:0]  idx;
    logic [TLIM_W:0]   last_byte;
    tbl_reg_t          tab;

    always_comb begin
        use_local  = sel[2];
        rpl        = sel[1:0];
        idx        = sel[SEL_W-1:ENT_SHIFT];
        tab        = use_local ? ltab : gtab;
        last_byte  = {1'b0, idx, {ENT_SHIFT{1'b0}}} + (TLIM_W+1)'(7);
        is_null    = !use_local && (idx == '0);
        in_range   = tab.present && (last_byte <= {1'b0, tab.limit});
        entry_addr = tab.base + SEG_AW'({idx, {ENT_SHIFT{1'b0}}});
    end
endmodule

// File: rtl/seg_desc_unpack.sv
module seg_desc_unpack
    import seg_pkg::*;
(
    input  logic [31:0]       lo_word,
    input  logic [31:0]       hi_word,
    output logic [SEG_AW-1:0] base,
    output logic [SLIM_W-1:0] limit,
    output logic [1:0]        dpl,
    output logic              is_code
);
    always_comb begin
        base    = {hi_word[31:24], hi_word[7:0], lo_word[31:16]};
        limit   = {hi_word[19:16], lo_word[15:0]};
        dpl     = hi_word[14:13];
        is_code = hi_word[11] & hi_word[12];
    end
endmodule

// File: rtl/seg_sel_loader.sv
module seg_sel_loader
    import seg_pkg::*;
#(
    parameter int ADDR_W = SEG_AW
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tbl_wr,
    input  logic              tbl_wr_local,
    input  logic [ADDR_W-1:0] tbl_wr_base,
    input  logic [15:0]       tbl_wr_limit,
    input  logic              tbl_wr_present,
    input  logic              sel_load,
    input  logic [15:0]       sel_in,
    output logic              busy,
    output logic              mem_req,
    output logic [ADDR_W-1:0] mem_addr,
    input  logic              mem_ack,
    input  logic [31:0]       mem_rdata,
    output logic              desc_valid,
    output logic [ADDR_W-1:0] desc_base,
    output logic [19:0]       desc_limit,
    output logic [1:0]        desc_dpl,
    output logic              fault,
    output logic [2:0]        fault_cause
);
    localparam logic [TLIM_W-1:0] RST_LIMIT = '1;
    localparam logic [SEG_AW-1:0] WORD_STEP = SEG_AW'(4);

    typedef struct packed {
        ld_state_e         st;
        logic [1:0]        rpl;
        logic [SEG_AW-1:0] addr;
        logic [31:0]       lo_word;
        tbl_reg_t          gtab;
        tbl_reg_t          ltab;
        logic              valid;
        logic              fault;
        cause_e            cause;
        logic [SEG_AW-1:0] dbase;
        logic [SLIM_W-1:0] dlimit;
        logic [1:0]        ddpl;
    } ld_regs_t;

    ld_regs_t r_d, r_q;

    logic [1:0]        dec_rpl;
    logic              dec_null;
    logic              dec_in_range;
    logic [SEG_AW-1:0] dec_addr;
    logic [SEG_AW-1:0] up_base;
    logic [SLIM_W-1:0] up_limit;
    logic [1:0]        up_dpl;
    logic              up_code;

    seg_sel_decode u_dec (
        .sel        (sel_in),
        .gtab       (r_q.gtab),
        .ltab       (r_q.ltab),
        .rpl        (dec_rpl),
        .is_null    (dec_null),
        .in_range   (dec_in_range),
        .entry_addr (dec_addr)
    );

    seg_desc_unpack u_unp (
        .lo_word (r_q.lo_word),
        .hi_word (mem_rdata),
        .base    (up_base),
        .limit   (up_limit),
        .dpl     (up_dpl),
        .is_code (up_code)
    );

    always_comb begin
        r_d       = r_q;
        r_d.valid = 1'b0;
        r_d.fault = 1'b0;
        r_d.cause = CAUSE_NONE;

        if (tbl_wr) begin
            if (tbl_wr_local) begin
                r_d.ltab = '{base: SEG_AW'(tbl_wr_base), limit: tbl_wr_limit,
                             present: tbl_wr_present};
            end else begin
                r_d.gtab = '{base: SEG_AW'(tbl_wr_base), limit: tbl_wr_limit,
                             present: 1'b1};
            end
        end

        unique case (r_q.st)
            ST_IDLE: begin
                if (sel_load) begin
                    if (dec_null) begin
                        r_d.fault = 1'b1;
                        r_d.cause = CAUSE_NULL;
                    end else if (!dec_in_range) begin
                        r_d.fault = 1'b1;
                        r_d.cause = CAUSE_LIMIT;
                    end else begin
                        r_d.st   = ST_LO;
                        r_d.addr = dec_addr;
                        r_d.rpl  = dec_rpl;
                    end
                end
            end
            ST_LO: begin
                if (mem_ack) begin
                    r_d.lo_word = mem_rdata;
                    r_d.st      = ST_HI;
                end
            end
            ST_HI: begin
                if (mem_ack) begin
                    r_d.st = ST_IDLE;
                    if (!up_code) begin
                        r_d.fault = 1'b1;
                        r_d.cause = CAUSE_TYPE;
                    end else if (r_q.rpl > up_dpl) begin
                        r_d.fault = 1'b1;
                        r_d.cause = CAUSE_PRIV;
                    end else begin
                        r_d.valid  = 1'b1;
                        r_d.dbase  = up_base;
                        r_d.dlimit = up_limit;
                        r_d.ddpl   = up_dpl;
                    end
                end
            end
            default: r_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            r_q      <= '0;
            r_q.st   <= ST_IDLE;
            r_q.gtab <= '{base: '0, limit: RST_LIMIT, present: 1'b1};
            r_q.ltab <= '{base: '0, limit: RST_LIMIT, present: 1'b1};
        end else begin
            r_q <= r_d;
        end
    end

    assign busy        = (r_q.st != ST_IDLE);
    assign mem_req     = busy;
    assign mem_addr    = ADDR_W'(r_q.addr + ((r_q.st == ST_HI) ? WORD_STEP : '0));
    assign desc_valid  = r_q.valid;
    assign desc_base   = ADDR_W'(r_q.dbase);
    assign desc_limit  = r_q.dlimit;
    assign desc_dpl    = r_q.ddpl;
    assign fault       = r_q.fault;
    assign fault_cause = r_q.cause;

    // R8: results are mutually exclusive and only leave an idle loader
    assert_one_result_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !(desc_valid && fault));
    assert_result_idle_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (desc_valid || fault) |-> !busy);
    assert_cause_quiet_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !fault |-> (fault_cause == 3'd0));
    // R3/R4: early faults never start a read
    assert_no_read_early_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && sel_load && (dec_null || !dec_in_range)) |=> !mem_req && fault);
    // R2: request held with stable address until acknowledged
    assert_addr_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_ack) |=> mem_req && $stable(mem_addr));
    assert_hi_after_lo_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.st == ST_LO && mem_ack) |=> mem_req && (mem_addr == $past(mem_addr) + 4));
    // R6: accepted descriptors satisfy the privilege rule
    assert_priv_ok_R6: assert property (@(posedge clk) disable iff (!rst_n)
        desc_valid |-> (r_q.rpl <= desc_dpl));
endmodule

// File: tb/sim_seg_sel_loader.sv
module sim_seg_sel_loader;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        tbl_wr = 1'b0, tbl_wr_local = 1'b0, tbl_wr_present = 1'b0;
    logic [31:0] tbl_wr_base = '0;
    logic [15:0] tbl_wr_limit = '0;
    logic        sel_load = 1'b0;
    logic [15:0] sel_in = '0;
    logic        busy, mem_req, mem_ack, desc_valid, fault;
    logic [31:0] mem_addr, mem_rdata, desc_base;
    logic [19:0] desc_limit;
    logic [1:0]  desc_dpl;
    logic [2:0]  fault_cause;

    int errors = 0;
    int checks = 0;
    int cycles = 0;

    logic [31:0] m_gbase = 0, m_lbase = 0;
    logic [15:0] m_glim = 16'hFFFF, m_llim = 16'hFFFF;
    logic        m_lpres = 1'b1;

    always #5 clk = ~clk;

    seg_sel_loader u0 (
        .clk, .rst_n, .tbl_wr, .tbl_wr_local, .tbl_wr_base, .tbl_wr_limit,
        .tbl_wr_present, .sel_load, .sel_in, .busy, .mem_req, .mem_addr,
        .mem_ack, .mem_rdata, .desc_valid, .desc_base, .desc_limit,
        .desc_dpl, .fault, .fault_cause
    );

    function automatic logic [31:0] memw(input logic [31:0] a);
        logic [31:0] h;
        h = (a * 32'h9E3779B1) ^ {a[15:0], a[31:16]};
        if (a[5]) h = h | 32'h0000_1800;
        return h;
    endfunction

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mem_ack   <= 1'b0;
            mem_rdata <= '0;
        end else begin
            mem_ack   <= mem_req && !mem_ack;
            mem_rdata <= memw(mem_addr);
        end
    end

    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (cycles > 150000) begin
            errors = errors + 1;
            checks = checks + 1;
            $display("FAIL watchdog: actual=hung expected=done");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic wr_tbl(input logic loc, input logic [31:0] b, input logic [15:0] l,
                          input logic p);
        @(negedge clk);
        tbl_wr = 1'b1; tbl_wr_local = loc; tbl_wr_base = b;
        tbl_wr_limit = l; tbl_wr_present = p;
        @(negedge clk);
        tbl_wr = 1'b0;
        if (loc) begin m_lbase = b; m_llim = l; m_lpres = p; end
        else begin m_gbase = b; m_glim = l; end
    endtask

    task automatic run_load(input logic [15:0] sel, input bit inject);
        logic        loc;
        logic [12:0] idx;
        logic [31:0] tb, a, lo, hi;
        logic [15:0] tl;
        logic [16:0] lastb;
        logic [2:0]  ecause;
        int          nreads;
        bit          done, injected;
        loc = sel[2];
        idx = sel[15:3];
        tb = loc ? m_lbase : m_gbase;
        tl = loc ? m_llim : m_glim;
        lastb = {1'b0, idx, 3'b000} + 17'd7;
        a = tb + {16'd0, idx, 3'b000};
        lo = memw(a);
        hi = memw(a + 4);
        if (!loc && idx == 0) ecause = 3'd1;
        else if ((loc && !m_lpres) || lastb > {1'b0, tl}) ecause = 3'd2;
        else if (!(hi[11] && hi[12])) ecause = 3'd3;
        else if (sel[1:0] > hi[14:13]) ecause = 3'd4;
        else ecause = 3'd0;

        @(negedge clk);
        chk("R8 idle before strobe", {31'd0, busy}, 32'd0);
        sel_in = sel; sel_load = 1'b1;
        @(negedge clk);
        sel_load = 1'b0;
        nreads = 0; done = 0; injected = 0;
        for (int c = 0; c < 40 && !done; c++) begin
            if (sel_load) sel_load = 1'b0;
            if (mem_req && mem_ack) begin
                chk("R2 read address", mem_addr, nreads == 0 ? a : a + 4);
                nreads++;
                if (inject && !injected) begin
                    injected = 1; sel_in = 16'h0000; sel_load = 1'b1;
                end
            end
            if (fault || desc_valid) done = 1;
            else @(negedge clk);
        end
        chk("R8 result arrived", {31'd0, done}, 32'd1);
        chk("R3/R4/R5/R6 fault cause", {29'd0, fault_cause}, {29'd0, ecause});
        chk("R8 one result kind", {30'd0, fault, desc_valid},
            ecause == 0 ? 32'd1 : 32'd2);
        chk("R4 read count", nreads, (ecause == 1 || ecause == 2) ? 0 : 2);
        if (ecause == 0) begin
            chk("R7 base", desc_base, {hi[31:24], hi[7:0], lo[31:16]});
            chk("R7 limit", {12'd0, desc_limit}, {12'd0, hi[19:16], lo[15:0]});
            chk("R7 dpl", {30'd0, desc_dpl}, {30'd0, hi[14:13]});
        end
        @(negedge clk);
        chk("R8 pulse width", {30'd0, fault, desc_valid}, 32'd0);
        chk("R8 ignored strobe", {31'd0, busy}, 32'd0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        chk("R1 reset busy/req", {30'd0, busy, mem_req}, 32'd0);
        chk("R1 reset pulses", {29'd0, fault, desc_valid, 1'b0}, 32'd0);
        chk("R1 reset cause", {29'd0, fault_cause}, 32'd0);
        rst_n = 1'b1;
        // R1: default tables, base 0 limit 0xFFFF, local present
        run_load(16'h0008, 0);
        run_load(16'h000C, 0);
        run_load(16'hFFF8, 0);
        run_load(16'hFFFF, 0);
        // R3: null selectors; local index 0 is not null
        run_load(16'h0000, 0);
        run_load(16'h0003, 0);
        run_load(16'h0004, 0);
        // R9: reprogram both tables, then sweep
        wr_tbl(1'b0, 32'h0001_0000, 16'h003F, 1'b1);
        wr_tbl(1'b1, 32'h0002_0040, 16'h0027, 1'b1);
        for (int t = 0; t < 2; t++)
            for (int i = 0; i < 12; i++)
                for (int r = 0; r < 4; r++)
                    run_load({i[12:0], t[0], r[1:0]}, 0);
        // R4: limit one byte short of the last entry
        wr_tbl(1'b0, 32'h0001_0000, 16'h003E, 1'b1);
        run_load(16'h0038, 0);
        run_load(16'h0030, 0);
        // R4: absent local table
        wr_tbl(1'b1, 32'h0002_0040, 16'hFFFF, 1'b0);
        run_load(16'h000C, 0);
        run_load(16'h0004, 0);
        // R8: strobe while busy is ignored
        wr_tbl(1'b1, 32'h0003_0000, 16'hFFFF, 1'b1);
        for (int i = 1; i < 5; i++) run_load({i[12:0], 3'b100}, 1);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule